// File: doc/BRIEF.md
# BT.656 Video Frame Timing Generator

This block produces the byte stream and sync pulses of an 8-bit BT.656 (YUV 4:2:2) video output. Each line is built from a byte position counter. Every line begins with an end-of-active-video code, then a programmable run of blanking samples, then a start-of-active-video code, then the programmable active region. Each line counter wraps after a programmable number of lines per field, and the field flag toggles at that point. The first lines of each field, up to a programmable count, are vertical blanking. Every output is registered and changes on the rising edge of the video clock.

Pixel bytes come in over a valid/ready stream. The timing of the output cannot stall, so `pix_ready` marks the clock slots in which a pixel byte will be placed on the bus. If an upstream source holds `pix_valid` low in such a slot, it gets no back-pressure. That slot carries the blanking code and nothing is consumed. The source may keep `pix_valid` high at any time, and a byte is taken only in a cycle where both signals are high. The block runs either as sync master, free-running from reset, or as a slave. In slave mode a selected edge on the frame-sync input starts exactly one frame of two fields, and the block idles between frames. Configuration inputs must stay stable while the block is out of reset.

Top module: `bt656_frame_gen`

## Requirements
- R1: During reset, `vo_data` is 80h, `hs_out` and `fs_out` are 0 and `pix_ready` is 0.
- R2: A line is 8 + 2·`cfg_hblank` + 2·`cfg_active` bytes long. Bytes 0–3 are the end-of-active code. The next 2·`cfg_hblank` bytes alternate 80h, 10h, starting with 80h. The next 4 bytes are the start-of-active code, and the active region follows. `cfg_hblank` must be at least 1.
- R3: Both timing codes are FFh, 00h, 00h, XY, where XY bit 7 = 1, bit 6 = F, bit 5 = V, bit 4 = H, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R4: In lines 0 to `cfg_vblank`−1 of each field, V is 1. In those lines the active region carries alternating 80h/10h (80h at even byte positions) and `pix_ready` stays low.
- R5: F is 0 in the first field. F toggles each time the line counter wraps after `cfg_lines` lines.
- R6: `pix_ready` is high exactly in the clock before an active-region byte of a line with V = 0 is driven. A byte accepted with `pix_valid` and `pix_ready` high appears on `vo_data` after the next rising edge. A slot with `pix_valid` low carries 80h at an even position or 10h at an odd position, and consumes nothing.
- R7: `hs_out` is high exactly while the four bytes of the end-of-active code are on `vo_data`.
- R8: In master mode, `fs_oe` is 1 and `fs_out` is high for every byte of line 0 of field 0. In slave mode, `fs_oe` and `fs_out` are 0.
- R9: The block is a slave only when `cfg_master` = 0 and `cfg_genlock` = 1. In every other setting it free-runs from reset, and its first byte after reset is FFh.
- R10: In slave mode, `cfg_fs_fall` = 0 selects the rising edge of `fs_in` and 1 selects the falling edge, and the other edge is ignored. If the selected edge is sampled at clock k, the first FFh is on `vo_data` after clock k+1.
- R11: A slave start emits exactly two fields. Selected edges that arrive during those fields are ignored. Afterwards, and after reset, the idle output alternates 80h, 10h starting with 80h, and `hs_out` and `pix_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | Sync master select |
| cfg_genlock | input | 1 | Genlock enable |
| cfg_fs_fall | input | 1 | Frame-sync edge select: 0 rising, 1 falling |
| cfg_hblank | input | H_W | Horizontal blanking, in byte pairs |
| cfg_active | input | H_W | Active pixels per line (two bytes each) |
| cfg_lines | input | V_W | Lines per field |
| cfg_vblank | input | V_W | Vertical-blanking lines at the start of each field |
| pix_valid | input | 1 | Pixel byte offered |
| pix_ready | output | 1 | Pixel slot in the next clock |
| pix_data | input | 8 | Pixel byte (Cb, Y, Cr, Y order) |
| vo_data | output | 8 | BT.656 byte stream |
| hs_out | output | 1 | Horizontal sync pulse |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Frame sync pulse |
| fs_oe | output | 1 | Frame-sync pin drive enable |

## Verification
The bench walks whole fields byte by byte and compares each byte with a model of the line layout. This covers the XY protection bits for every F and V combination. A design with a wrong parity term or a swapped F/V bit would put a bad fourth code byte on the first mismatching line. Holding `pix_valid` low for one active line checks that the slot is filled with the right blanking parity and that the pixel counter does not advance. A design that stalled or consumed the byte anyway would shift every later pixel. In slave mode the bench first drives the opposite edge, then the selected edge, then a second selected edge in the middle of the frame. A design that decoded edges wrongly, restarted on the later edge, or ran more or fewer than two fields would break the idle alternation or misplace the first FFh.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  localparam logic [7:0] CODE_LEAD  = 8'hFF;
  localparam logic [7:0] CODE_ZERO  = 8'h00;
  localparam logic [7:0] BLANK_CHR  = 8'h80;
  localparam logic [7:0] BLANK_LUM  = 8'h10;

  typedef enum logic [1:0] {
    RG_EAV,
    RG_HBLK,
    RG_SAV,
    RG_ACT
  } region_e;

  // Timing-reference status word with protection bits
  function automatic logic [7:0] trs_xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // Blanking sample: chroma level at even positions, luma level at odd ones
  function automatic logic [7:0] blank_code(input logic odd);
    return odd ? BLANK_LUM : BLANK_CHR;
  endfunction

endpackage

// File: rtl/bt656_counters.sv
module bt656_counters #(
  parameter int PW = 13,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [PW-1:0] line_len,
  input  logic [VW-1:0] field_lines,
  output logic [PW-1:0] pos,
  output logic [VW-1:0] line,
  output logic          field,
  output logic          frame_last
);

  logic pos_end;
  logic line_end;

  assign pos_end    = (pos == line_len - PW'(1));
  assign line_end   = (line == field_lines - VW'(1));
  assign frame_last = pos_end & line_end & field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      line  <= '0;
      field <= 1'b0;
    end else if (adv) begin
      if (pos_end) begin
        pos <= '0;
        if (line_end) begin
          line  <= '0;
          field <= ~field;
        end else begin
          line <= line + VW'(1);
        end
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end

endmodule

// File: rtl/bt656_genlock.sv
module bt656_genlock (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic fall_sel,
  input  logic fs_in,
  input  logic frame_last,
  output logic run_en
);

  logic fs_q;
  logic running;
  logic hit;

  assign hit    = fall_sel ? (fs_q & ~fs_in) : (~fs_q & fs_in);
  assign run_en = slave ? running : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      running <= 1'b0;
    end else begin
      fs_q <= fs_in;
      if (!slave)
        running <= 1'b0;
      else if (!running && hit)
        running <= 1'b1;
      else if (running && frame_last)
        running <= 1'b0;
    end
  end

endmodule

// File: rtl/bt656_byte_sel.sv
module bt656_byte_sel
  import bt656_pkg::*;
#(
  parameter int HW = 10,
  parameter int PW = 13,
  parameter int VW = 10
) (
  input  logic [PW-1:0] pos,
  input  logic [VW-1:0] line,
  input  logic          field,
  input  logic          run_en,
  input  logic          idle_phase,
  input  logic [HW-1:0] hblank,
  input  logic [VW-1:0] vblank,
  input  logic          pix_valid,
  input  logic [7:0]    pix_data,
  output logic [7:0]    byte_nxt,
  output logic          hs_nxt,
  output logic          fs_nxt,
  output logic          pix_ready
);

  logic [PW-1:0] sav_at;
  logic [PW-1:0] act_at;
  logic [1:0]    code_idx;
  logic          v_bit;
  logic          h_bit;
  region_e       region;

  assign sav_at = PW'(4) + PW'({hblank, 1'b0});
  assign act_at = sav_at + PW'(4);
  assign v_bit  = (line < vblank);

  always_comb begin
    if (pos < PW'(4))
      region = RG_EAV;
    else if (pos < sav_at)
      region = RG_HBLK;
    else if (pos < act_at)
      region = RG_SAV;
    else
      region = RG_ACT;
  end

  assign h_bit    = (region == RG_EAV);
  assign code_idx = h_bit ? pos[1:0] : (pos[1:0] - sav_at[1:0]);

  assign pix_ready = run_en & (region == RG_ACT) & ~v_bit;
  assign hs_nxt    = run_en & h_bit;
  assign fs_nxt    = run_en & (line == '0) & ~field;

  always_comb begin
    if (!run_en) begin
      byte_nxt = blank_code(idle_phase);
    end else begin
      unique case (region)
        RG_EAV, RG_SAV: begin
          unique case (code_idx)
            2'd0:    byte_nxt = CODE_LEAD;
            2'd3:    byte_nxt = trs_xy(field, v_bit, h_bit);
            default: byte_nxt = CODE_ZERO;
          endcase
        end
        RG_HBLK: byte_nxt = blank_code(pos[0]);
        default: byte_nxt = (pix_ready && pix_valid) ? pix_data : blank_code(pos[0]);
      endcase
    end
  end

endmodule

// File: rtl/bt656_frame_gen.sv
module bt656_frame_gen #(
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_master,
  input  logic           cfg_genlock,
  input  logic           cfg_fs_fall,
  input  logic [H_W-1:0] cfg_hblank,
  input  logic [H_W-1:0] cfg_active,
  input  logic [V_W-1:0] cfg_lines,
  input  logic [V_W-1:0] cfg_vblank,
  input  logic           pix_valid,
  output logic           pix_ready,
  input  logic [7:0]     pix_data,
  output logic [7:0]     vo_data,
  output logic           hs_out,
  input  logic           fs_in,
  output logic           fs_out,
  output logic           fs_oe
);

  localparam int PW = H_W + 3;

  logic          slave;
  logic          run_en;
  logic          frame_last;
  logic          idle_phase;
  logic [PW-1:0] line_len;
  logic [PW-1:0] pos;
  logic [V_W-1:0] line;
  logic          field;
  logic [7:0]    byte_nxt;
  logic          hs_nxt;
  logic          fs_nxt;

  assign slave    = ~cfg_master & cfg_genlock;
  assign fs_oe    = ~slave;
  assign line_len = PW'(8) + PW'({cfg_hblank, 1'b0}) + PW'({cfg_active, 1'b0});

  bt656_genlock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave      (slave),
    .fall_sel   (cfg_fs_fall),
    .fs_in      (fs_in),
    .frame_last (frame_last),
    .run_en     (run_en)
  );

  bt656_counters #(.PW(PW), .VW(V_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (run_en),
    .line_len    (line_len),
    .field_lines (cfg_lines),
    .pos         (pos),
    .line        (line),
    .field       (field),
    .frame_last  (frame_last)
  );

  bt656_byte_sel #(.HW(H_W), .PW(PW), .VW(V_W)) u_sel (
    .pos        (pos),
    .line       (line),
    .field      (field),
    .run_en     (run_en),
    .idle_phase (idle_phase),
    .hblank     (cfg_hblank),
    .vblank     (cfg_vblank),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .byte_nxt   (byte_nxt),
    .hs_nxt     (hs_nxt),
    .fs_nxt     (fs_nxt),
    .pix_ready  (pix_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo_data    <= bt656_pkg::BLANK_CHR;
      hs_out     <= 1'b0;
      fs_out     <= 1'b0;
      idle_phase <= 1'b0;
    end else begin
      vo_data    <= byte_nxt;
      hs_out     <= hs_nxt;
      fs_out     <= fs_nxt & ~slave;
      idle_phase <= run_en ? 1'b0 : ~idle_phase;
    end
  end

endmodule

// File: rtl/bt656_frame_gen_chk.sv
module bt656_frame_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic [7:0] pix_data,
  input logic [7:0] vo_data,
  input logic       hs_out,
  input logic       fs_out,
  input logic       fs_oe
);

  // R7
  eav_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_out) |-> vo_data == 8'hFF);

  // R3
  eav_xy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && $past(hs_out) && $past(hs_out, 2) && $past(hs_out, 3)) |->
      (vo_data[7] && vo_data[4] &&
       vo_data[3] == (vo_data[5] ^ vo_data[4]) &&
       vo_data[2] == (vo_data[6] ^ vo_data[4]) &&
       vo_data[1] == (vo_data[6] ^ vo_data[5]) &&
       vo_data[0] == (vo_data[6] ^ vo_data[5] ^ vo_data[4])));

  // R2
  hblank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_out) |-> vo_data == 8'h80);

  // R6
  pix_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> vo_data == $past(pix_data));

  // R8
  fs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |-> fs_oe);

endmodule

bind bt656_frame_gen bt656_frame_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_data  (pix_data),
  .vo_data   (vo_data),
  .hs_out    (hs_out),
  .fs_out    (fs_out),
  .fs_oe     (fs_oe)
);

// File: tb/bt656_frame_gen_test.sv
`timescale 1ns/1ps
module bt656_frame_gen_test;

  localparam int HB  = 2;
  localparam int ACT = 4;
  localparam int FL  = 4;
  localparam int VB  = 1;
  localparam int LEN = 8 + 2*HB + 2*ACT;
  localparam int FRAME = 2*FL*LEN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b1;
  logic       cfg_genlock = 1'b0;
  logic       cfg_fs_fall = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic       fs_in = 1'b0;
  logic       pix_ready;
  logic [7:0] vo_data;
  logic       hs_out;
  logic       fs_out;
  logic       fs_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int idle_ph = 0;
  int pix_cnt = 0;

  always #2 clk = ~clk;

  bt656_frame_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_master  (cfg_master),
    .cfg_genlock (cfg_genlock),
    .cfg_fs_fall (cfg_fs_fall),
    .cfg_hblank  (10'(HB)),
    .cfg_active  (10'(ACT)),
    .cfg_lines   (10'(FL)),
    .cfg_vblank  (10'(VB)),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .pix_data    (pix_data),
    .vo_data     (vo_data),
    .hs_out      (hs_out),
    .fs_in       (fs_in),
    .fs_out      (fs_out),
    .fs_oe       (fs_oe)
  );

  task automatic chk(input bit ok, input string req, input string ctx, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0h expected %0h", req, ctx, act, exp);
    end
  endtask

  function automatic logic [7:0] xy(input int f, input int v, input int h);
    logic bf, bv, bh;
    bf = (f != 0); bv = (v != 0); bh = (h != 0);
    return {1'b1, bf, bv, bh, bv ^ bh, bf ^ bh, bf ^ bv, bf ^ bv ^ bh};
  endfunction

  function automatic logic [7:0] blank(input int p);
    return (p % 2 == 1) ? 8'h10 : 8'h80;
  endfunction

  function automatic logic [7:0] model(input int p, input int l, input int f, input bit take, input logic [7:0] pd);
    int v;
    v = (l < VB) ? 1 : 0;
    if (p < 4)               return (p == 0) ? 8'hFF : (p == 3) ? xy(f, v, 1) : 8'h00;
    else if (p < 4 + 2*HB)   return blank(p);
    else if (p < 8 + 2*HB) begin
      int k;
      k = p - (4 + 2*HB);
      return (k == 0) ? 8'hFF : (k == 3) ? xy(f, v, 0) : 8'h00;
    end
    else if (v == 1 || !take) return blank(p);
    else                      return pd;
  endfunction

  task automatic do_reset(input bit m, input bit g, input bit fall);
    cfg_master = m; cfg_genlock = g; cfg_fs_fall = fall;
    rst_n = 1'b0; fs_in = 1'b0; pix_valid = 1'b0;
    pix_cnt = 0; pix_data = 8'h00; idle_ph = 0;
    repeat (3) @(negedge clk);
    chk(vo_data === 8'h80, "R1", "reset data", vo_data, 8'h80);
    chk(hs_out === 1'b0 && fs_out === 1'b0, "R1", "reset sync", {hs_out, fs_out}, 0);
    chk(pix_ready === 1'b0, "R1", "reset ready", pix_ready, 0);
    rst_n = 1'b1;
  endtask

  task automatic check_idle(input int n, input string ctx);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      @(posedge clk); @(negedge clk);
      e = (idle_ph != 0) ? 8'h10 : 8'h80;
      chk(vo_data === e, "R11", ctx, vo_data, e);
      chk(hs_out === 1'b0 && pix_ready === 1'b0, "R11", ctx, {hs_out, pix_ready}, 0);
      idle_ph = 1 - idle_ph;
    end
  endtask

  // Walks n bytes from the start of a frame, comparing with the line model.
  task automatic run_bytes(input int n, input bit master, input bit poke, input string ctx);
    int mp, ml, mf;
    mp = 0; ml = 0; mf = 0;
    chk(fs_oe === master, "R8", ctx, fs_oe, master);
    for (int i = 0; i < n; i++) begin
      bit slot, ok;
      logic [7:0] e;
      string tag;
      slot = (mp >= 8 + 2*HB) && (ml >= VB);
      ok   = !(ml == 2 && mf == 1);
      pix_valid = ok;
      if (poke && (i == 40 || i == 50)) fs_in = ~fs_in;
      chk(pix_ready === slot, "R6", ctx, pix_ready, slot);
      @(posedge clk); @(negedge clk);
      e = model(mp, ml, mf, ok, pix_cnt[7:0]);
      if (mp < 4 || (mp >= 4 + 2*HB && mp < 8 + 2*HB)) tag = "R3 R5";
      else if (mp < 4 + 2*HB)                           tag = "R2";
      else if (ml < VB)                                 tag = "R4";
      else                                              tag = "R6";
      chk(vo_data === e, tag, ctx, vo_data, e);
      chk(hs_out === (mp < 4), "R7", ctx, hs_out, mp < 4);
      chk(fs_out === (master && ml == 0 && mf == 0), "R8", ctx, fs_out, master && ml == 0 && mf == 0);
      if (slot && ok) begin
        pix_cnt++;
        pix_data = pix_cnt[7:0];
      end
      mp++;
      if (mp == LEN) begin
        mp = 0; ml++;
        if (ml == FL) begin ml = 0; mf = 1 - mf; end
      end
    end
  endtask

  task automatic t_master;
    do_reset(1'b1, 1'b0, 1'b0);
    run_bytes(2*FRAME, 1'b1, 1'b0, "master two frames");
  endtask

  task automatic t_master_settings;
    do_reset(1'b1, 1'b1, 1'b0);
    run_bytes(LEN*2, 1'b1, 1'b0, "R9 master with genlock bit");
    do_reset(1'b0, 1'b0, 1'b0);
    run_bytes(LEN*2, 1'b1, 1'b0, "R9 neither bit");
  endtask

  task automatic t_genlock(input bit fall);
    do_reset(1'b0, 1'b1, fall);
    check_idle(6, "R11 idle after reset");
    fs_in = 1'b1;
    if (fall) begin
      check_idle(6, "R10 opposite edge ignored");
      fs_in = 1'b0;
    end
    check_idle(1, "R10 edge sampled");
    run_bytes(FRAME, 1'b0, 1'b1, fall ? "R10 falling start" : "R10 rising start");
    idle_ph = 0;
    check_idle(LEN + 10, "R11 idle after two fields");
  endtask

  initial begin
    t_master;
    t_master_settings;
    t_genlock(1'b0);
    t_genlock(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule